// File: doc/BRIEF.md
# Quad Prescaled Countdown Timer Bank

This block holds four independent 24-bit countdown timers behind one small register window. Each timer counts down from a programmable start value. It counts on every clock, on every 16th clock or on every 256th clock. When the count runs out, the timer raises its own sticky interrupt line. In periodic mode the timer reloads itself and keeps running. In one-shot mode it stops at zero until software restarts it.

Software uses the bus as follows. Bits 6:5 of the byte address choose the timer, and bits 3:2 choose one of four registers inside that timer. Writing the start value arms the count. The control register sets the enable, periodic and prescale bits. Any access to the acknowledge register drops the interrupt, and in periodic mode it also restarts the count. Read data is a combinational function of the address alone, so a read with `bus_valid` low has no side effect. The four interrupt lines go to an external interrupt collector.

Each timer runs a state machine with three states:
- **T_IDLE**: disabled, and the count is frozen.
- **T_RUN**: counting on prescaler ticks.
- **T_DONE**: a one-shot timer that has expired and is parked at zero.

The transitions are:
- **T_IDLE → T_RUN**: a control write with enable set.
- **T_RUN → T_IDLE**: a control write with enable clear.
- **T_RUN → T_DONE**: a one-shot expiry.
- **T_DONE → T_RUN**: a control write with enable set, or a start-value write.
- **T_DONE → T_IDLE**: a control write with enable clear.

Top module: `ctimer_bank`

## Requirements
- R1: After reset, every timer reads start value 0xFFFFFF, count 0 and control 0x2 (periodic, disabled), and all interrupt lines are low.
- R2: Byte address bits 6:5 select the timer, and bits 3:2 select the register: 0 start value, 1 count, 2 control, 3 acknowledge. An access to one timer leaves the other timers and their interrupt lines untouched.
- R3: A start-value write keeps bits 23:0 only, copies them into the count, and drops that timer's interrupt.
- R4: The control bits are bit0 enable, bit1 periodic, bit2 divide-by-16 and bit3 divide-by-256. A control write with enable set reloads the count from the start value and restarts the prescaler. A control write with enable clear freezes the count. Both kinds of control write drop the interrupt.
- R5: A control write with both bit2 and bit3 set is discarded. Control, count and interrupt are all unchanged.
- R6: With no prescale bit set and start value L ≥ 1, the interrupt rises on the L-th clock edge after the enabling control write, and not earlier. The count reads L−k after k edges.
- R7: With divide-by-16 the expiry comes after 16·L edges. With divide-by-256 it comes after 256·L edges.
- R8: In periodic mode, an expiry reloads the count from the start value and counting continues. The interrupt stays high until it is acknowledged.
- R9: In one-shot mode, an expiry leaves the count at 0 and counting stops. A later start-value write restarts the count from the new value.
- R10: Any access to the acknowledge register, read or write, drops the interrupt. In periodic mode it also reloads the count. In one-shot mode the count is left unchanged.
- R11: A count write keeps bits 23:0 only, and a running timer continues counting down from the written value.
- R12: Reads of the acknowledge register and of offsets 0x10 to 0x1F return 0. Writes to offsets 0x10 to 0x1F change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tmr_irq | output | 4 | Sticky interrupt line, one per timer |

## Verification
The divide-by-256 expiry is the hardest situation to reach from the ports, because it lies hundreds of cycles after the enabling write. The bench gets there by arming a small start value and counting idle cycles exactly, checking the line one edge before expiry and again on the expiry edge. The one-shot parked state needs its own stimulus. The bench lets the timer expire, idles it for many cycles, acknowledges it, and then restarts it with a start-value write rather than a control write. This confirms that the T_DONE → T_RUN path works and that the acknowledge leaves the count alone.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_RUN  = 2'd1,
        T_DONE = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        RG_START = 2'd0,
        RG_COUNT = 2'd1,
        RG_CTRL  = 2'd2,
        RG_ACK   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic d256;
        logic d16;
        logic per;
        logic en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{d256: 1'b0, d16: 1'b0, per: 1'b1, en: 1'b0};
endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
    parameter int DIV_A_LOG2 = 4,
    parameter int DIV_B_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic sel_a_i,
    input  logic sel_b_i,
    output logic tick_o
);
    localparam int PS_W = DIV_B_LOG2;

    logic [PS_W-1:0] cnt_q;
    logic            wrap_a;
    logic            wrap_b;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap_a = &cnt_q[DIV_A_LOG2-1:0];
    assign wrap_b = &cnt_q;

    always_comb begin
        if (!run_i || restart_i) begin
            tick_o = 1'b0;
        end else if (sel_b_i) begin
            tick_o = wrap_b;
        end else if (sel_a_i) begin
            tick_o = wrap_a;
        end else begin
            tick_o = 1'b1;
        end
    end
endmodule

// File: rtl/ctb_timer.sv
module ctb_timer
    import ctb_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int DIV_A_LOG2 = 4,
    parameter int DIV_B_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             wr_i,
    input  reg_sel_e         reg_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] count_o,
    output ctrl_t            ctrl_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] START_MAX = {CNT_W{1'b1}};

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] start_q, count_q;
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             irq_q;
    logic             tick;
    logic             st_wr, cnt_wr, ctl_raw, ctl_bad, ctl_wr, ack_hit, upd;
    logic             expire;

    assign ctrl_new = ctrl_t'(wdata_i[CTRL_W-1:0]);
    assign st_wr    = hit_i && wr_i && (reg_i == RG_START);
    assign cnt_wr   = hit_i && wr_i && (reg_i == RG_COUNT);
    assign ctl_raw  = hit_i && wr_i && (reg_i == RG_CTRL);
    assign ctl_bad  = ctrl_new.d16 && ctrl_new.d256;
    assign ctl_wr   = ctl_raw && !ctl_bad;
    assign ack_hit  = hit_i && (reg_i == RG_ACK);
    assign upd      = st_wr || cnt_wr || ctl_wr || ack_hit;
    assign expire   = (state_q == T_RUN) && tick && !upd && (count_q <= CNT_W'(1));

    ctb_prescaler #(
        .DIV_A_LOG2 (DIV_A_LOG2),
        .DIV_B_LOG2 (DIV_B_LOG2)
    ) u_ps (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == T_RUN),
        .restart_i (ctl_wr),
        .sel_a_i   (ctrl_q.d16),
        .sel_b_i   (ctrl_q.d256),
        .tick_o    (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: begin
                if (ctl_wr && ctrl_new.en) state_d = T_RUN;
            end
            T_RUN: begin
                if (ctl_wr && !ctrl_new.en)  state_d = T_IDLE;
                else if (expire && !ctrl_q.per) state_d = T_DONE;
            end
            T_DONE: begin
                if (ctl_wr)     state_d = ctrl_new.en ? T_RUN : T_IDLE;
                else if (st_wr) state_d = T_RUN;
            end
            default: state_d = T_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= START_MAX;
            count_q <= '0;
            ctrl_q  <= CTRL_RESET;
            irq_q   <= 1'b0;
        end else if (st_wr) begin
            start_q <= wdata_i;
            count_q <= wdata_i;
            irq_q   <= 1'b0;
        end else if (cnt_wr) begin
            count_q <= wdata_i;
        end else if (ctl_wr) begin
            ctrl_q <= ctrl_new;
            irq_q  <= 1'b0;
            if (ctrl_new.en) count_q <= start_q;
        end else if (ack_hit) begin
            irq_q <= 1'b0;
            if (ctrl_q.per) count_q <= start_q;
        end else if (expire) begin
            irq_q   <= 1'b1;
            count_q <= ctrl_q.per ? start_q : '0;
        end else if ((state_q == T_RUN) && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign start_o = start_q;
    assign count_o = count_q;
    assign ctrl_o  = ctrl_q;
    assign irq_o   = irq_q;

    a_r8_irq_rises_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(state_q) == T_RUN);

    a_r10_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> !irq_q);

    a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE && !upd) |=> $stable(count_q));

    a_r5_bad_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_raw && ctl_bad) |=> $stable(ctrl_q));

    a_r9_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_DONE && !upd) |=> (state_q == T_DONE && $stable(count_q)));

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && !tick && !upd) |=> $stable(count_q));
endmodule

// File: rtl/ctimer_bank.sv
module ctimer_bank
    import ctb_pkg::*;
#(
    parameter int NUM_TIMERS  = 4,
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 32,
    parameter int STRIDE_LOG2 = 5,
    parameter int ADDR_W      = STRIDE_LOG2 + $clog2(NUM_TIMERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TIMERS-1:0] tmr_irq
);
    localparam int SEL_W = ADDR_W - STRIDE_LOG2;

    logic [SEL_W-1:0]       sel;
    logic [STRIDE_LOG2-1:0] off;
    logic                   off_known;
    reg_sel_e               rsel;
    logic [CNT_W-1:0]       start_a [NUM_TIMERS];
    logic [CNT_W-1:0]       count_a [NUM_TIMERS];
    ctrl_t                  ctrl_a  [NUM_TIMERS];
    logic                   unused_bits;

    assign sel         = bus_addr[ADDR_W-1:STRIDE_LOG2];
    assign off         = bus_addr[STRIDE_LOG2-1:0];
    assign off_known   = (off[STRIDE_LOG2-1:4] == '0);
    assign rsel        = reg_sel_e'(off[3:2]);
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], off[1:0]};

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        logic hit;
        assign hit = bus_valid && off_known && (sel == SEL_W'(g));

        ctb_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit),
            .wr_i    (bus_write),
            .reg_i   (rsel),
            .wdata_i (bus_wdata[CNT_W-1:0]),
            .start_o (start_a[g]),
            .count_o (count_a[g]),
            .ctrl_o  (ctrl_a[g]),
            .irq_o   (tmr_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (off_known && (int'(sel) < NUM_TIMERS)) begin
            unique case (rsel)
                RG_START: bus_rdata[CNT_W-1:0]  = start_a[sel];
                RG_COUNT: bus_rdata[CNT_W-1:0]  = count_a[sel];
                RG_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_a[sel];
                RG_ACK:   bus_rdata = '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq[0]) |-> $past(ctrl_a[0].en));
endmodule

// File: tb/ctimer_bank_tb.sv
`timescale 1ns/1ps
module ctimer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tmr_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ctimer_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    localparam int O_START = 0, O_COUNT = 4, O_CTRL = 8, O_ACK = 12;

    function automatic logic [6:0] adr(input int t, input int o);
        return 7'((t << 5) + o);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic peek(input int t, input int o, output logic [31:0] d);
        bus_addr = adr(t, o);
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input int t, input int o, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(t, o); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int t, input int o, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = adr(t, o);
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int t = 0; t < 4; t++) begin
            peek(t, O_START, d); chk("R1 start", d, 32'hFFFFFF);
            peek(t, O_COUNT, d); chk("R1 count", d, 0);
            peek(t, O_CTRL, d);  chk("R1 ctrl", d, 32'h2);
        end
        chk("R1 irq", {28'd0, tmr_irq}, 0);
    endtask

    task automatic t_start_write;
        logic [31:0] d;
        wr(0, O_START, 32'h12345678);
        peek(0, O_START, d); chk("R3 start masked", d, 32'h345678);
        peek(0, O_COUNT, d); chk("R3 copied to count", d, 32'h345678);
        peek(1, O_START, d); chk("R2 other timer untouched", d, 32'hFFFFFF);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(0, O_START, 5);
        wr(0, O_CTRL, 32'h1);
        peek(0, O_COUNT, d); chk("R6 count after enable", d, 5);
        repeat (2) @(negedge clk);
        peek(0, O_COUNT, d); chk("R6 count after 2 edges", d, 3);
        repeat (2) @(negedge clk);
        chk("R6 no early irq", {31'd0, tmr_irq[0]}, 0);
        @(negedge clk);
        chk("R6 irq on edge L", {28'd0, tmr_irq}, 32'h1);
        peek(0, O_COUNT, d); chk("R9 parked at zero", d, 0);
        repeat (10) @(negedge clk);
        peek(0, O_COUNT, d); chk("R9 still zero", d, 0);
        chk("R8 irq sticky", {31'd0, tmr_irq[0]}, 1);
        wr(0, O_ACK, 0);
        chk("R10 ack drops irq", {31'd0, tmr_irq[0]}, 0);
        peek(0, O_COUNT, d); chk("R10 one-shot ack no reload", d, 0);
        wr(0, O_START, 3);
        repeat (2) @(negedge clk);
        chk("R9 restart not yet", {31'd0, tmr_irq[0]}, 0);
        @(negedge clk);
        chk("R9 restart expires", {31'd0, tmr_irq[0]}, 1);
        wr(0, O_CTRL, 0);
        chk("R4 disable drops irq", {31'd0, tmr_irq[0]}, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] d, v1, v2;
        wr(1, O_START, 4);
        wr(1, O_CTRL, 32'h3);
        repeat (3) @(negedge clk);
        chk("R6 periodic no early irq", {31'd0, tmr_irq[1]}, 0);
        @(negedge clk);
        chk("R8 irq at expiry", {31'd0, tmr_irq[1]}, 1);
        peek(1, O_COUNT, d); chk("R8 reload at expiry", d, 4);
        @(negedge clk);
        peek(1, O_COUNT, d); chk("R8 keeps counting", d, 3);
        repeat (3) @(negedge clk);
        chk("R8 irq still high", {31'd0, tmr_irq[1]}, 1);
        rd(1, O_ACK, d);
        chk("R12 ack reads zero", d, 0);
        chk("R10 read ack drops irq", {31'd0, tmr_irq[1]}, 0);
        peek(1, O_COUNT, d); chk("R10 periodic ack reloads", d, 4);
        wr(1, O_CTRL, 32'h2);
        peek(1, O_COUNT, v1);
        repeat (10) @(negedge clk);
        peek(1, O_COUNT, v2);
        chk("R4 disabled count frozen", v2, v1);
        chk("R4 disabled irq low", {31'd0, tmr_irq[1]}, 0);
    endtask

    task automatic t_prescale;
        wr(2, O_START, 3);
        wr(2, O_CTRL, 32'h5);
        repeat (47) @(negedge clk);
        chk("R7 div16 not early", {31'd0, tmr_irq[2]}, 0);
        @(negedge clk);
        chk("R7 div16 expiry", {31'd0, tmr_irq[2]}, 1);
        wr(2, O_CTRL, 0);
        wr(2, O_START, 2);
        wr(2, O_CTRL, 32'h9);
        repeat (511) @(negedge clk);
        chk("R7 div256 not early", {31'd0, tmr_irq[2]}, 0);
        @(negedge clk);
        chk("R7 div256 expiry", {31'd0, tmr_irq[2]}, 1);
        wr(2, O_CTRL, 0);
    endtask

    task automatic t_illegal_and_count;
        logic [31:0] d;
        wr(3, O_CTRL, 32'hD);
        peek(3, O_CTRL, d);  chk("R5 ctrl kept", d, 32'h2);
        repeat (20) @(negedge clk);
        peek(3, O_COUNT, d); chk("R5 count kept", d, 0);
        chk("R5 irq low", {31'd0, tmr_irq[3]}, 0);
        wr(3, O_START, 100);
        wr(3, O_CTRL, 32'h1);
        wr(3, O_COUNT, 32'hFF000002);
        peek(3, O_COUNT, d); chk("R11 count masked", d, 2);
        @(negedge clk);
        chk("R11 not yet", {31'd0, tmr_irq[3]}, 0);
        @(negedge clk);
        chk("R11 expires from written", {31'd0, tmr_irq[3]}, 1);
        wr(3, O_CTRL, 32'h1);
        peek(3, O_COUNT, d); chk("R4 enable reloads", d, 100);
        chk("R4 enable drops irq", {31'd0, tmr_irq[3]}, 0);
        wr(3, O_CTRL, 0);
    endtask

    task automatic t_decode;
        logic [31:0] d;
        peek(0, 16, d); chk("R12 unknown offset reads zero", d, 0);
        wr(0, 16, 32'hABC);
        peek(0, O_START, d); chk("R12 write ignored start", d, 3);
        peek(0, O_CTRL, d);  chk("R12 write ignored ctrl", d, 0);
        wr(2, O_START, 7);
        peek(0, O_START, d); chk("R2 timer0 unaffected", d, 3);
        peek(2, O_START, d); chk("R2 timer2 written", d, 7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_write();
        t_oneshot();
        t_periodic();
        t_prescale();
        t_illegal_and_count();
        t_decode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule